// File: doc/BRIEF.md
# Burst SRAM with Write Forwarding

A synthesizable model of a double-data-rate burst memory. It has one shared address bus and two active-low command selects, one for reads and one for writes, both sampled on the rising clock edge. Every access moves four words through an aligned group of four locations. Write data arrives on a DDR input bus. Read data leaves on a DDR output bus with a latency of two and a half cycles, and a valid flag marks the read window.

A write does not reach the storage array until its last word has arrived. Until then, its group is held in a small staging buffer. A read that targets that group while the write is still staged gets the new words from the buffer. A read therefore always sees every write issued in an earlier cycle. Outside a read window the data bus is released to high impedance.

Top module: `qdr_burst_sram`

## Requirements
- R1: While rst_n is low, and after it is released, qvld stays low and the data bus is released until a read is accepted.
- R2: A write accepted at rising edge N takes its four data words from wdata at the rising edge of N+1, the falling edge after it, the rising edge of N+2 and the falling edge after that, in that order.
- R3: Burst word k of an access at address A is located at {A[AW-1:2], (A[1:0]+k) mod 4}. The burst wraps inside its aligned group of four.
- R4: For a read accepted at rising edge N, word 0 is driven from the falling edge after edge N+2. Words 1, 2 and 3 follow, each one half cycle after the previous word.
- R5: qvld is high exactly from the falling edge after edge N+2 to the falling edge after edge N+4. At every other time qvld is low and q is high impedance.
- R6: A read accepted one cycle after a write to the same group returns the words of that write, although they have not yet reached the array.
- R7: When a read and a write are selected in the same cycle, both use the same address. The read returns the contents from before that write. A later read returns the new contents.
- R8: A read select in the cycle right after an accepted read is ignored. A write select in the cycle right after an accepted write is ignored, and its data is never stored.
- R9: Reads accepted every second cycle give an unbroken valid window, with one word on every clock edge.
- R10: A cycle with neither select active changes neither the memory nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands on the rising edge, data on both edges |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_n | input | 1 | Active-low read select |
| wr_n | input | 1 | Active-low write select |
| addr | input | AW | Burst start address, shared by read and write |
| wdata | input | DW | DDR write data |
| q | output | DW | DDR read data, high impedance outside the read window |
| qvld | output | 1 | High while q carries read data |

## Verification
- **Read timing.** Read words are due in four half-cycle slots. The first slot starts at the falling edge that comes two and a half cycles after the read edge.
- **Half-cycle numbering.** The bench numbers half cycles and computes the slot index of each expected word when it issues the read. A monitor samples q and qvld in the middle of every half cycle. It compares q with the front of the queue when the index matches, and otherwise expects qvld low.
- **Write data timing.** Write words are placed on wdata for the edge that captures them: the two edges after the command edge for the first pair, and the two edges after those for the second pair.
- **Reference memory.** The reference memory applies each write after any read in the same cycle. This gives the forwarding case and the same-cycle case their correct expected values.

// File: rtl/qbs_pkg.sv
package qbs_pkg;
   localparam int BEATS  = 4;
   localparam int LANE_W = 2;

   // location of burst word 'off' inside the aligned group
   function automatic logic [LANE_W-1:0] lane_of(input logic [LANE_W-1:0] base,
                                                 input logic [LANE_W-1:0] off);
      return base + off;
   endfunction
endpackage

// File: rtl/qbs_write_capture.sv
module qbs_write_capture
   import qbs_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 18
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_go,
   input  logic [AW-1:0]             wr_addr,
   input  logic [DW-1:0]             wdata,
   output logic                      commit_en,
   output logic [AW-1:0]             commit_addr,
   output logic [BEATS-1:0][DW-1:0]  commit_words
);
   logic          st1, st2, st3;
   logic [AW-1:0] ad1, ad2, ad3;
   logic [DW-1:0] word0, word1, word2, fall_word;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st1 <= 1'b0;
         st2 <= 1'b0;
         st3 <= 1'b0;
      end else begin
         st1 <= wr_go;
         st2 <= st1;
         st3 <= st2;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_go) ad1 <= wr_addr;
      ad2 <= ad1;
      ad3 <= ad2;
      if (st1) word0 <= wdata;
      if (st2) begin
         word1 <= fall_word;
         word2 <= wdata;
      end
   end

   // falling-edge capture: word 1 while st2 is set, word 3 while st3 is set
   always_ff @(negedge clk) begin
      if (st2 || st3) fall_word <= wdata;
   end

   assign commit_en    = st3;
   assign commit_addr  = ad3;
   assign commit_words = {fall_word, word2, word1, word0};
endmodule

// File: rtl/qbs_store.sv
module qbs_store
   import qbs_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 18
) (
   input  logic                      clk,
   input  logic                      commit_en,
   input  logic [AW-1:0]             commit_addr,
   input  logic [BEATS-1:0][DW-1:0]  commit_words,
   input  logic                      cap_en,
   input  logic [AW-1:0]             cap_addr,
   output logic [BEATS-1:0][DW-1:0]  burst
);
   localparam int DEPTH = 1 << AW;
   localparam int GW    = AW - LANE_W;

   logic [DW-1:0] mem [DEPTH];

   logic [AW-1:0]     wr_loc  [BEATS];
   logic [AW-1:0]     rd_loc  [BEATS];
   logic [LANE_W-1:0] fwd_sel [BEATS];
   logic              grp_hit;

   assign grp_hit = commit_en && (commit_addr[AW-1:LANE_W] == cap_addr[AW-1:LANE_W]);

   for (genvar k = 0; k < BEATS; k++) begin : g_lane
      assign wr_loc[k]  = {commit_addr[AW-1:LANE_W],
                           lane_of(commit_addr[LANE_W-1:0], LANE_W'(k))};
      assign rd_loc[k]  = {cap_addr[AW-1:LANE_W],
                           lane_of(cap_addr[LANE_W-1:0], LANE_W'(k))};
      assign fwd_sel[k] = rd_loc[k][LANE_W-1:0] - commit_addr[LANE_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (commit_en) begin
         for (int k = 0; k < BEATS; k++) mem[wr_loc[k]] <= commit_words[k];
      end
   end

   // the read sees the array before this edge, plus the burst committing now
   always_ff @(posedge clk) begin
      if (cap_en) begin
         for (int k = 0; k < BEATS; k++)
            burst[k] <= grp_hit ? commit_words[fwd_sel[k]] : mem[rd_loc[k]];
      end
   end

   logic [GW-1:0] unused_grp;
   assign unused_grp = '0;
endmodule

// File: rtl/qbs_read_drive.sv
module qbs_read_drive
   import qbs_pkg::*;
#(
   parameter int DW = 18
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [BEATS-1:0][DW-1:0]  burst,
   output logic [DW-1:0]             q,
   output logic                      qvld
);
   logic          ph1, ph2, oe;
   logic [DW-1:0] rise_q, fall_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph1 <= 1'b0;
         ph2 <= 1'b0;
      end else begin
         ph1 <= start;
         ph2 <= ph1;
      end
   end

   always_ff @(posedge clk) begin
      if (ph1)      rise_q <= burst[1];
      else if (ph2) rise_q <= burst[3];
   end

   always_ff @(negedge clk) begin
      if (!rst_n) oe <= 1'b0;
      else        oe <= ph1 | ph2;
      if (ph1)      fall_q <= burst[0];
      else if (ph2) fall_q <= burst[2];
   end

   assign qvld = oe;
   assign q    = oe ? (clk ? rise_q : fall_q) : 'z;
endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram
   import qbs_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_n,
   input  logic          wr_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] q,
   output logic          qvld
);
   if (AW < LANE_W + 1) begin : g_bad_aw
      $error("qdr_burst_sram: AW must exceed the burst lane bits");
   end
   if (DW < 1) begin : g_bad_dw
      $error("qdr_burst_sram: DW must be positive");
   end

   logic                     rd_go, wr_go, rd_busy, wr_busy, rd_s2;
   logic [AW-1:0]            ra1, ra2;
   logic                     commit_en;
   logic [AW-1:0]            commit_addr;
   logic [BEATS-1:0][DW-1:0] commit_words;
   logic [BEATS-1:0][DW-1:0] burst;

   assign rd_go = rst_n & ~rd_n & ~rd_busy;
   assign wr_go = rst_n & ~wr_n & ~wr_busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_busy <= 1'b0;
         wr_busy <= 1'b0;
         rd_s2   <= 1'b0;
      end else begin
         rd_busy <= rd_go;
         wr_busy <= wr_go;
         rd_s2   <= rd_busy;
      end
   end

   always_ff @(posedge clk) begin
      if (rd_go) ra1 <= addr;
      ra2 <= ra1;
   end

   qbs_write_capture #(.AW(AW), .DW(DW)) u_wcap (
      .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .wr_addr(addr), .wdata(wdata),
      .commit_en(commit_en), .commit_addr(commit_addr), .commit_words(commit_words)
   );

   qbs_store #(.AW(AW), .DW(DW)) u_store (
      .clk(clk), .commit_en(commit_en), .commit_addr(commit_addr),
      .commit_words(commit_words), .cap_en(rd_s2), .cap_addr(ra2), .burst(burst)
   );

   qbs_read_drive #(.DW(DW)) u_rdrv (
      .clk(clk), .rst_n(rst_n), .start(rd_s2), .burst(burst), .q(q), .qvld(qvld)
   );
endmodule

// File: rtl/qdr_burst_sram_chk.sv
module qdr_burst_sram_chk (
   input logic clk,
   input logic rst_n,
   input logic rd_go,
   input logic wr_go,
   input logic commit_en,
   input logic qvld
);
   // R5: valid window covers the two rising edges after the read latency
   a_r5_vld_head: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_go, 3) |-> qvld);
   a_r5_vld_tail: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_go, 4) |-> qvld);
   a_r5_vld_cause: assert property (@(posedge clk) disable iff (!rst_n)
      qvld |-> ($past(rd_go, 3) || $past(rd_go, 4)));
   // R2: a write burst commits three cycles after its command
   a_r2_commit_delay: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_go, 3) |-> commit_en);
   a_r2_commit_cause: assert property (@(posedge clk) disable iff (!rst_n)
      commit_en |-> $past(wr_go, 3));
   // R8: write bursts never commit in adjacent cycles
   a_r8_commit_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      commit_en |=> !commit_en);
endmodule

bind qdr_burst_sram qdr_burst_sram_chk u_chk (
   .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .wr_go(wr_go),
   .commit_en(commit_en), .qvld(qvld)
);

// File: tb/sim_qdr_burst_sram.sv
module sim_qdr_burst_sram;
   localparam int AW = 8;
   localparam int DW = 18;
   localparam int SLOTS = 4096;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_n = 1'b1, wr_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   wire  [DW-1:0] q;
   wire           qvld;

   qdr_burst_sram #(.AW(AW), .DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .wdata(wdata), .q(q), .qvld(qvld)
   );

   always #10 clk = ~clk;   // 50 MHz

   int pe = 0;
   always @(posedge clk) pe++;

   int checks = 0, fails = 0;
   bit done = 0;

   logic [DW-1:0] ref_mem [1<<AW];
   logic [DW-1:0] wp [SLOTS];
   logic [DW-1:0] wn [SLOTS];
   int last_rd = -10, last_wr = -10;

   typedef struct { int h; logic [DW-1:0] d; string tag; } exp_t;
   exp_t sb[$];

   function automatic logic [AW-1:0] loc(input logic [AW-1:0] a, input int k);
      return {a[AW-1:2], 2'(a[1:0] + 2'(k))};
   endfunction

   task automatic check(input string tag, input bit ok, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // one command cycle; inputs set mid-low before the sampling edge
   task automatic tick(input bit r, input bit w, input logic [AW-1:0] a,
                       input logic [3:0][DW-1:0] d, input string tag);
      int n;
      @(negedge clk); #5;
      n = pe + 1;
      rd_n = !r; wr_n = !w; addr = a; wdata = wp[n];
      if (r && n != last_rd + 1) begin
         last_rd = n;
         for (int k = 0; k < 4; k++)
            sb.push_back('{h: 2*n + 5 + k, d: ref_mem[loc(a, k)], tag: tag});
      end
      if (w && n != last_wr + 1) begin
         last_wr = n;
         for (int k = 0; k < 4; k++) ref_mem[loc(a, k)] = d[k];
         wp[n+1] = d[0]; wn[n+1] = d[1];
         wp[n+2] = d[2]; wn[n+2] = d[3];
      end
      @(posedge clk); #5;
      wdata = wn[n];
   endtask

   task automatic idle(input int cnt);
      for (int i = 0; i < cnt; i++) tick(0, 0, '0, '0, "R10");
   endtask

   function automatic logic [3:0][DW-1:0] pat(input int s);
      logic [3:0][DW-1:0] v;
      for (int k = 0; k < 4; k++) v[k] = DW'(s * 131 + k * 7 + 3);
      return v;
   endfunction

   // monitor: sample mid-phase, half index 2*pe (high) or 2*pe+1 (low)
   task automatic sample(input int h);
      if (sb.size() > 0 && sb[0].h == h) begin
         check(sb[0].tag, qvld === 1'b1 && q === sb[0].d, q, sb[0].d);
         void'(sb.pop_front());
      end else begin
         check(rst_n ? "R5" : "R1", qvld === 1'b0, {17'b0, qvld}, '0);
      end
   endtask

   initial begin
      repeat (2) @(posedge clk);
      forever begin
         @(posedge clk); #5; sample(2*pe);
         @(negedge clk); #5; sample(2*pe + 1);
      end
   end

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < SLOTS; i++) begin wp[i] = '0; wn[i] = '0; end
      idle(4);
      check("R1", qvld === 1'b0, {17'b0, qvld}, '0);
      @(negedge clk); #5; rst_n = 1'b1;
      idle(3);
      check("R1", qvld === 1'b0, {17'b0, qvld}, '0);

      // prefill every group (R2)
      for (int g = 0; g < (1 << (AW-2)); g++) begin
         tick(0, 1, AW'(g*4), pat(g), "R2");
         idle(1);
      end
      idle(3);
      tick(1, 0, 8'h10, '0, "R2");
      idle(4);
      tick(1, 0, 8'h14, '0, "R4");
      idle(4);

      // R3 wrap: write starting at lane 3, read starting at lane 1
      tick(0, 1, 8'h23, pat(500), "R3");
      idle(3);
      tick(1, 0, 8'h21, '0, "R3");
      idle(4);

      // R6 forwarding: read right after write, same group
      tick(0, 1, 8'h40, pat(600), "R6");
      tick(1, 0, 8'h42, '0, "R6");
      idle(4);

      // R7 same-cycle read and write
      tick(1, 1, 8'h50, pat(700), "R7");
      idle(3);
      tick(1, 0, 8'h50, '0, "R7");
      idle(4);

      // R8 ignored reads and writes
      tick(1, 0, 8'h60, '0, "R8");
      tick(1, 0, 8'h70, '0, "R8");
      idle(4);
      tick(0, 1, 8'h80, pat(800), "R8");
      tick(0, 1, 8'h90, pat(900), "R8");
      idle(3);
      tick(1, 0, 8'h90, '0, "R8");
      idle(1);
      tick(1, 0, 8'h80, '0, "R8");
      idle(4);

      // R9 reads every second cycle
      for (int i = 0; i < 4; i++) begin
         tick(1, 0, AW'(8'hA0 + i*5), '0, "R9");
         idle(1);
      end
      idle(4);

      // mixed traffic
      for (int i = 0; i < 400; i++) begin
         automatic int rv = int'($urandom_range(0, 3));
         tick(rv[0], rv[1], AW'($urandom_range(0, (1<<AW)-1)),
              pat(int'($urandom_range(1000, 9000))), "R10");
      end
      idle(8);
      check("R4", sb.size() == 0, DW'(sb.size()), '0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule